// File: doc/BRIEF.md
# Peripheral Chip Select Generator

This block turns bus addresses into seven active-low peripheral select lines. Each select covers its own fixed-size block inside a region whose start comes from a base register. When the bus interface presents an address phase, the block drives the matching select for the whole bus cycle. It holds a ready output low for a programmed number of wait clocks, then raises ready for one clock to end the cycle.

The select outputs stay dead after reset. They come alive only once software has touched both configuration registers, the base register and the auxiliary register, at least once each. A read counts as a touch just as a write does. Selects 0 to 3 share an uneven wait-state set of eight values. Selects 5 and 6 share a plain 0 to 3 range. Select 4 does not exist, and its line never leaves the high state.

The address input carries block-granular bits only (address bits ADDR_W-1 down to BLK_W). The default is a 16-bit address with 128-byte blocks, so the region is 1 KiB aligned.

Top module: `pcs_gen`

## Requirements
- R1: After reset all `pcs_n` lines are high, `bus_rdy` is low, and both registers read back as zero.
- R2: A strobe is ignored until both registers (`reg_sel`=0 base, `reg_sel`=1 auxiliary) have each been read or written once since reset. A strobe in the same cycle as the access that completes this condition is also ignored.
- R3: With address bits [15:10] equal to base bits [15:10], address bits [9:7] give the block number n. Blocks 0-3, 5 and 6 assert `pcs_n[n]`. Block 4, block 7 and any address outside the region assert nothing.
- R4: `pcs_n[4]` is high at all times.
- R5: Selects 0-3 take their wait count from base bits [2:0]. Codes 0..7 map to 0, 1, 2, 3, 5, 7, 9, 15 clocks.
- R6: Selects 5 and 6 take their wait count from auxiliary bits [1:0] (0-3 clocks). Base bits [2:0] do not affect them.
- R7: The select goes low on the clock after the strobe. For a count W, `bus_rdy` stays low for W clocks and is then high for exactly one clock. The select goes high on the clock after that.
- R8: At most one select is low at any time. A strobe that arrives while a cycle is in progress is ignored.
- R9: The base register reads back only bits [15:10] and [2:0]. The auxiliary register reads back only bits [1:0]. All other bits read as zero. Reads are combinational, and a write takes effect on the next clock.
- R10: A register write in the same cycle as a strobe does not affect that bus cycle. The cycle uses the old wait code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 base, 1 auxiliary |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |
| bus_strb | input | 1 | Address-phase strobe, one clock |
| bus_blk_addr | input | 9 | Bus address bits [15:7] |
| pcs_n | output | 7 | Active-low peripheral selects |
| bus_rdy | output | 1 | One-clock ready pulse ending the cycle |

## Verification
Register configuration and the address phase can land in the same clock. The bench provokes this in two ways. First, it raises the strobe together with the access that completes enabling, and expects no select at all. Second, it raises the strobe together with a base write that changes the wait code, and expects the bus cycle to run with the old count. The next strobe must then use the new count. A second overlap is a strobe during a running cycle. That case is judged by the original select and the original ready timing staying intact.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int NUM_CS     = 7;
    localparam int UNUSED_CS  = 4;
    localparam int WAIT_W     = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_st_e;

    // Uneven wait set for the low selects: 0,1,2,3,5,7,9,15
    function automatic logic [WAIT_W-1:0] lo_wait(input logic [2:0] code);
        logic [WAIT_W-1:0] w;
        if (!code[2])
            w = {2'b00, code[1:0]};
        else if (code == 3'd7)
            w = 4'd15;
        else
            w = {code, 1'b0} - 4'd3;
        return w;
    endfunction

    function automatic logic [WAIT_W-1:0] hi_wait(input logic [1:0] code);
        return {2'b00, code};
    endfunction
endpackage

// File: rtl/pcs_cfg.sv
module pcs_cfg
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    output logic [ADDR_W-BLK_W-4:0] base_o,
    output logic [2:0]           lo_code_o,
    output logic [1:0]           hi_code_o,
    output logic                 en_o
);
    localparam int BASE_LSB = BLK_W + 3;
    localparam int BASE_W   = ADDR_W - BASE_LSB;
    localparam logic [ADDR_W-1:0] BASE_MASK =
        {{BASE_W{1'b1}}, {(BASE_LSB-3){1'b0}}, 3'b111};
    localparam logic [ADDR_W-1:0] AUX_MASK = {{(ADDR_W-2){1'b0}}, 2'b11};

    typedef struct packed {
        logic [ADDR_W-1:0] base_reg;
        logic [ADDR_W-1:0] aux_reg;
        logic              seen_base;
        logic              seen_aux;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr || reg_rd) begin
            if (reg_sel) cfg_d.seen_aux  = 1'b1;
            else         cfg_d.seen_base = 1'b1;
        end
        if (reg_wr) begin
            if (reg_sel) cfg_d.aux_reg  = reg_wdata & AUX_MASK;
            else         cfg_d.base_reg = reg_wdata & BASE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign reg_rdata = reg_sel ? cfg_q.aux_reg : cfg_q.base_reg;
    assign base_o    = cfg_q.base_reg[ADDR_W-1:BASE_LSB];
    assign lo_code_o = cfg_q.base_reg[2:0];
    assign hi_code_o = cfg_q.aux_reg[1:0];
    assign en_o      = cfg_q.seen_base & cfg_q.seen_aux;

    // R2
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> en_o);

    // R2
    en_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !reg_wr && !reg_rd) |=> !en_o);
endmodule

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 7
) (
    input  logic [ADDR_W-BLK_W-1:0] blk_addr,
    input  logic [ADDR_W-BLK_W-4:0] base,
    output logic [NUM_CS-1:0]       hit
);
    localparam int HI_W = ADDR_W - BLK_W;

    logic       in_region;
    logic [2:0] blk_num;

    assign in_region = (blk_addr[HI_W-1:3] == base);
    assign blk_num   = blk_addr[2:0];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_hit
        if (i == UNUSED_CS) begin : g_absent
            assign hit[i] = 1'b0;
        end else begin : g_present
            assign hit[i] = in_region && (blk_num == 3'(i));
        end
    end
endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb,
    input  logic              en,
    input  logic [NUM_CS-1:0] hit,
    input  logic [2:0]        lo_code,
    input  logic [1:0]        hi_code,
    output logic [NUM_CS-1:0] cs_n,
    output logic              rdy
);
    typedef struct packed {
        seq_st_e           st;
        logic [NUM_CS-1:0] sel;
        logic [WAIT_W-1:0] cnt;
        logic              rdy;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [WAIT_W-1:0] wait_pick;

    always_comb begin
        wait_pick = (|hit[3:0]) ? lo_wait(lo_code) : hi_wait(hi_code);
        seq_d     = seq_q;
        case (seq_q.st)
            SEQ_IDLE: begin
                seq_d.rdy = 1'b0;
                if (strb && en && (|hit)) begin
                    seq_d.st  = SEQ_BUSY;
                    seq_d.sel = hit;
                    seq_d.cnt = wait_pick;
                    seq_d.rdy = (wait_pick == '0);
                end
            end
            default: begin
                if (seq_q.rdy) begin
                    seq_d.st  = SEQ_IDLE;
                    seq_d.sel = '0;
                    seq_d.cnt = '0;
                    seq_d.rdy = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                    seq_d.rdy = (seq_q.cnt == WAIT_W'(1));
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, sel: '0, cnt: '0, rdy: 1'b0};
        else        seq_q <= seq_d;
    end

    assign cs_n = ~seq_q.sel;
    assign rdy  = seq_q.rdy;

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4
    cs4_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n[UNUSED_CS]);

    // R7
    rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> ((&cs_n) && !rdy));

    // R7
    rdy_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> !(&cs_n));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !rdy) |=> $stable(cs_n));

    // R2
    no_cs_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (&cs_n));
endmodule

// File: rtl/pcs_gen.sv
module pcs_gen
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_sel,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_wdata,
    output logic [ADDR_W-1:0]       reg_rdata,
    input  logic                    bus_strb,
    input  logic [ADDR_W-BLK_W-1:0] bus_blk_addr,
    output logic [NUM_CS-1:0]       pcs_n,
    output logic                    bus_rdy
);
    localparam int BASE_W = ADDR_W - BLK_W - 3;

    logic [BASE_W-1:0] base;
    logic [2:0]        lo_code;
    logic [1:0]        hi_code;
    logic              en;
    logic [NUM_CS-1:0] hit;

    pcs_cfg #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .base_o    (base),
        .lo_code_o (lo_code),
        .hi_code_o (hi_code),
        .en_o      (en)
    );

    pcs_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .blk_addr (bus_blk_addr),
        .base     (base),
        .hit      (hit)
    );

    pcs_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (bus_strb),
        .en      (en),
        .hit     (hit),
        .lo_code (lo_code),
        .hi_code (hi_code),
        .cs_n    (pcs_n),
        .rdy     (bus_rdy)
    );
endmodule

// File: tb/pcs_gen_bench.sv
module pcs_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_strb = 1'b0;
    logic [8:0]  bus_blk_addr = '0;
    logic [6:0]  pcs_n;
    logic        bus_rdy;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pcs_gen u_pcs_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .bus_strb     (bus_strb),
        .bus_blk_addr (bus_blk_addr),
        .pcs_n        (pcs_n),
        .bus_rdy      (bus_rdy)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [2:0]  lo;
        logic [1:0]  hi;
        logic [2:0]  idx;   // 7 = no select
        logic [3:0]  w;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'h2400, 3'd0, 2'd0, 3'd0, 4'd0},
        '{16'h2485, 3'd3, 2'd0, 3'd1, 4'd3},
        '{16'h2510, 3'd4, 2'd0, 3'd2, 4'd5},
        '{16'h25A0, 3'd5, 2'd0, 3'd3, 4'd7},
        '{16'h2600, 3'd6, 2'd1, 3'd7, 4'd0},
        '{16'h26C0, 3'd0, 2'd2, 3'd5, 4'd2},
        '{16'h2700, 3'd0, 2'd3, 3'd6, 4'd3},
        '{16'h2790, 3'd1, 2'd1, 3'd7, 4'd0},
        '{16'h2800, 3'd1, 2'd1, 3'd7, 4'd0},
        '{16'h2410, 3'd7, 2'd0, 3'd0, 4'd15},
        '{16'h2690, 3'd7, 2'd1, 3'd5, 4'd1},
        '{16'h2050, 3'd2, 2'd2, 3'd7, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_cs(input logic [2:0] idx);
        return (idx == 3'd7) ? 7'h7F : ~(7'h01 << idx);
    endfunction

    task automatic wr(input logic sel, input logic [15:0] data);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic sel, input logic [15:0] exp,
                          input string req);
        reg_sel = sel; reg_rd = 1'b1;
        #1;
        chk(reg_rdata == exp, req, "readback", reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic access(input logic [15:0] addr, input logic [2:0] idx,
                          input logic [3:0] w, input string req);
        bus_strb = 1'b1; bus_blk_addr = addr[15:7];
        @(negedge clk);
        bus_strb = 1'b0;
        if (idx == 3'd7) begin
            chk(pcs_n == 7'h7F && !bus_rdy, req, "no select",
                {pcs_n, bus_rdy}, {7'h7F, 1'b0});
        end else begin
            for (int k = 0; k <= int'(w); k++) begin
                chk(pcs_n == exp_cs(idx) && bus_rdy == (k == int'(w)), req,
                    "select/ready", {pcs_n, bus_rdy},
                    {exp_cs(idx), k == int'(w)});
                @(negedge clk);
            end
            // R7 release after ready
            chk(pcs_n == 7'h7F && !bus_rdy, "R7", "release",
                {pcs_n, bus_rdy}, {7'h7F, 1'b0});
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state of outputs
        chk(pcs_n == 7'h7F, "R1", "pcs_n after reset", pcs_n, 7'h7F);
        chk(!bus_rdy, "R1", "rdy after reset", bus_rdy, 0);

        // R2: only base accessed -> strobe ignored
        wr(1'b0, 16'h2400);
        access(16'h2400, 3'd7, 4'd0, "R2");
        // R2: strobe in same cycle as completing access -> ignored
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0000;
        access(16'h2400, 3'd7, 4'd0, "R2");
        reg_wr = 1'b0;
        access(16'h2400, 3'd0, 4'd0, "R2");

        // R1 register reset values; reads alone enable (R2)
        do_reset();
        rd_chk(1'b0, 16'h0000, "R1");
        rd_chk(1'b1, 16'h0000, "R1");
        access(16'h0000, 3'd0, 4'd0, "R2");

        // R9 readback masks
        wr(1'b0, 16'hFFFF);
        rd_chk(1'b0, 16'hFC07, "R9");
        wr(1'b1, 16'hFFFF);
        rd_chk(1'b1, 16'h0003, "R9");

        // R3 R4 R5 R6 table walk
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, 16'h2400 | 16'(VECS[v].lo));
            wr(1'b1, 16'(VECS[v].hi));
            access(VECS[v].addr, VECS[v].idx, VECS[v].w,
                   VECS[v].idx == 3'd7 ? "R3" :
                   (VECS[v].idx < 3'd4 ? "R5" : "R6"));
        end

        // R8: second strobe during a running cycle is ignored
        wr(1'b0, 16'h2407);
        bus_strb = 1'b1; bus_blk_addr = 9'h048;
        @(negedge clk);
        bus_blk_addr = 9'h049;
        for (int k = 0; k <= 15; k++) begin
            chk(pcs_n == 7'h7E && bus_rdy == (k == 15), "R8", "busy strobe",
                {pcs_n, bus_rdy}, {7'h7E, k == 15});
            @(negedge clk);
            bus_strb = 1'b0;
        end
        chk(pcs_n == 7'h7F, "R8", "after busy", pcs_n, 7'h7F);

        // R10: write with strobe in same cycle uses old wait code
        wr(1'b0, 16'h2400);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 16'h2403;
        access(16'h2400, 3'd0, 4'd0, "R10");
        reg_wr = 1'b0;
        access(16'h2400, 3'd0, 4'd3, "R10");

        // R4 select 4 block again with generous wait code
        access(16'h2610, 3'd7, 4'd0, "R4");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule